// File: doc/BRIEF.md
# Successive-Approximation ADC Capture Sequencer

This block drives an external 8-bit successive-approximation converter through its active-low select, write-strobe, read-strobe and completion-flag pins. It gathers a programmed number of samples into a memory buffer with no processor involvement. A one-cycle start request carries the number of samples to take. The sequencer then repeats a fixed loop: trigger a conversion, wait for the completion flag, read the byte, write it to the buffer, and move the buffer pointer on by one.

The converter runs from its own slow clock, so one conversion can last hundreds or thousands of system clocks. The sequencer waits for as long as the conversion takes. It acts only on the completion flag after that flag has passed through a synchronizer. The write and read strobes are held low for a fixed minimum number of clocks, and chip select stays low for the whole of each strobe. When the last sample has been written, the block drops its busy output and pulses done.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `adc_cs_n`, `adc_wr_n` and `adc_rd_n` are 1, and `busy`, `done` and `mem_we` are 0.
- R2: A start request with a nonzero count, made while idle, raises `busy` and begins a conversion. `adc_wr_n` is held low for exactly PULSE_CLKS clocks, and its rising edge triggers the converter.
- R3: After the trigger, the sequencer waits for `adc_intr_n` to go low, however long that takes. It then holds `adc_rd_n` low for exactly PULSE_CLKS clocks, and it never drives `adc_rd_n` low before a completion has been flagged.
- R4: The byte present on `adc_data` at the end of the read strobe is written to memory. Sample k (k counted from 0 in each run) goes to address BUF_BASE + k, default 0x7000. `mem_we` is high for exactly one clock per sample.
- R5: After each stored sample, a new conversion starts unless the count is used up. Exactly `count_i` samples are stored in each run, for any count from 1 to 255.
- R6: `done` is high for exactly one clock, the clock after the final sample is written. In that clock `busy` is already 0.
- R7: A start request made while `busy` is 1 is ignored. The run in progress stores neither more nor fewer samples than it was started with.
- R8: A start request with a count of 0 is ignored. `busy` stays 0, no strobe falls and no memory write occurs.
- R9: `adc_wr_n` and `adc_rd_n` are never low together. `adc_cs_n` is low exactly in the clocks in which one of the two strobes is low.
- R10: `adc_intr_n` passes through a two-flop synchronizer. `adc_rd_n` falls exactly three clocks after `adc_intr_n` is first seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request to begin a capture run |
| count_i | input | CNT_W | Number of samples to take, sampled with `start_i` |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_wr_n | output | 1 | Converter conversion-trigger strobe, active low |
| adc_rd_n | output | 1 | Converter result-read strobe, active low |
| adc_intr_n | input | 1 | Converter completion flag, active low, asynchronous |
| adc_data | input | DATA_W | Converter result byte |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | ADDR_W | Buffer write address |
| mem_wdata | output | DATA_W | Buffer write data |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse after the final sample is stored |

## Verification
The properties assume the converter behaves correctly. Once it pulls `adc_intr_n` low, the flag stays low until a read strobe is seen, and `adc_data` does not change between the flag falling and the end of the read. The read strobe must clear the flag before the synchronized copy could be sampled again. The bench's converter model keeps to all of this. It raises the flag only a set number of clocks after the write strobe rises, holds its data register fixed until the next conversion ends, and clears the flag on the first clock in which it sees the read strobe low. Start requests are always single-cycle pulses driven away from the clock edge.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TRIG  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_FETCH = 3'd3,
    ST_STORE = 3'd4
  } acq_state_e;
endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/acq_pulse_timer.sv
module acq_pulse_timer #(
  parameter int PULSE_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int PW_W = (PULSE_CLKS < 2) ? 1 : $clog2(PULSE_CLKS + 1);

  logic [PW_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = run ? cnt_q + PW_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == PW_W'(PULSE_CLKS - 1));
endmodule

// File: rtl/acq_buf_ptr.sv
module acq_buf_ptr #(
  parameter int                ADDR_W   = 16,
  parameter int                CNT_W    = 8,
  parameter logic [ADDR_W-1:0] BUF_BASE = 16'h7000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              en;

  assign en = load | advance;

  always_comb begin
    ptr_d = ptr_q;
    rem_d = rem_q;
    if (load) begin
      ptr_d = BUF_BASE;
      rem_d = cnt_i;
    end else if (advance) begin
      ptr_d = ptr_q + ADDR_W'(1);
      rem_d = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= BUF_BASE;
      rem_q <= '0;
    end else if (en) begin
      ptr_q <= ptr_d;
      rem_q <= rem_d;
    end
  end

  assign addr_o = ptr_q;
  assign last_o = (rem_q == CNT_W'(1));
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
  import acq_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter int                ADDR_W     = 16,
  parameter int                CNT_W      = 8,
  parameter logic [ADDR_W-1:0] BUF_BASE   = 16'h7000,
  parameter int                PULSE_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              adc_cs_n,
  output logic              adc_wr_n,
  output logic              adc_rd_n,
  input  logic              adc_intr_n,
  input  logic [DATA_W-1:0] adc_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done
);
  localparam int SYNC_STAGES = 2;

  logic              rst_ni;
  logic              intr_s_n;
  logic              tmr_run, tmr_exp;
  logic              ptr_load, ptr_adv, ptr_last;
  logic              rdata_en;
  logic              done_d, done_q;
  logic [DATA_W-1:0] rdata_q;
  acq_state_e        state_q, state_d;

  // reset: asserted asynchronously, released on a clock edge
  acq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ni)
  );

  // completion flag from the converter's clock domain
  acq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_intr_sync (
    .clk(clk), .rst_n(rst_ni), .d(adc_intr_n), .q(intr_s_n)
  );

  acq_pulse_timer #(.PULSE_CLKS(PULSE_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_ni), .run(tmr_run), .expire(tmr_exp)
  );

  acq_buf_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUF_BASE(BUF_BASE)) u_ptr (
    .clk(clk), .rst_n(rst_ni), .load(ptr_load), .cnt_i(count_i),
    .advance(ptr_adv), .addr_o(mem_addr), .last_o(ptr_last)
  );

  assign tmr_run = (state_q == ST_TRIG) || (state_q == ST_FETCH);

  always_comb begin
    state_d  = state_q;
    ptr_load = 1'b0;
    ptr_adv  = 1'b0;
    rdata_en = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && (count_i != '0)) begin
          ptr_load = 1'b1;
          state_d  = ST_TRIG;
        end
      end
      ST_TRIG: begin
        if (tmr_exp) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!intr_s_n) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        if (tmr_exp) begin
          rdata_en = 1'b1;
          state_d  = ST_STORE;
        end
      end
      ST_STORE: begin
        ptr_adv = 1'b1;
        if (ptr_last) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_TRIG;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (rdata_en) rdata_q <= adc_data;
  end

  assign adc_wr_n  = (state_q != ST_TRIG);
  assign adc_rd_n  = (state_q != ST_FETCH);
  assign adc_cs_n  = adc_wr_n & adc_rd_n;
  assign mem_we    = (state_q == ST_STORE);
  assign mem_wdata = rdata_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
endmodule

// File: rtl/adc_capture_ctrl_chk.sv
module adc_capture_ctrl_chk #(
  parameter int PULSE_CLKS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic adc_cs_n,
  input logic adc_wr_n,
  input logic adc_rd_n,
  input logic adc_intr_n,
  input logic mem_we,
  input logic busy,
  input logic done
);
  logic [15:0] wr_lo_q, rd_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_lo_q <= '0;
      rd_lo_q <= '0;
    end else begin
      wr_lo_q <= adc_wr_n ? 16'd0 : wr_lo_q + 16'd1;
      rd_lo_q <= adc_rd_n ? 16'd0 : rd_lo_q + 16'd1;
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!adc_wr_n && !adc_rd_n));

  // R9
  select_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n) == (!adc_wr_n || !adc_rd_n));

  // R2
  trig_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_wr_n) |-> (wr_lo_q == 16'(PULSE_CLKS)));

  // R3
  fetch_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rd_n) |-> (rd_lo_q == 16'(PULSE_CLKS)));

  // R10
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_rd_n) |-> (!$past(adc_intr_n, 2) && !adc_intr_n));

  // R4
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(mem_we)));
endmodule

bind adc_capture_ctrl adc_capture_ctrl_chk #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n),
  .adc_rd_n(adc_rd_n), .adc_intr_n(adc_intr_n), .mem_we(mem_we),
  .busy(busy), .done(done)
);

// File: tb/sim_adc_capture_ctrl.sv
`timescale 1ns/1ps
module sim_adc_capture_ctrl;
  localparam int              PW   = 3;
  localparam logic [15:0]     BASE = 16'h7000;
  // {count[31:24], conversion clocks[23:8], seed[7:0]}
  localparam logic [31:0] VEC [6] = '{
    {8'd1,  16'd5,    8'h00},
    {8'd4,  16'd3,    8'h11},
    {8'd7,  16'd40,   8'hF0},
    {8'd3,  16'd1,    8'h80},
    {8'd12, 16'd9,    8'h5A},
    {8'd2,  16'd2000, 8'h33}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  count_i;
  logic        adc_cs_n, adc_wr_n, adc_rd_n;
  logic        adc_intr_n;
  logic [7:0]  adc_data;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_capture_ctrl #(.PULSE_CLKS(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n),
    .adc_intr_n(adc_intr_n), .adc_data(adc_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done)
  );

  // ---------------- converter model ----------------
  int   conv_len = 5;
  logic [7:0] seed_v = 8'h00;
  int   conv_k = 0;
  int   conv_left = 0;
  logic wr_prev = 1'b1;

  always @(posedge clk) begin
    wr_prev <= adc_wr_n;
    if (!rst_n) begin
      adc_intr_n <= 1'b1;
      adc_data   <= 8'h00;
      conv_left  <= 0;
    end else begin
      if (!adc_wr_n && wr_prev) begin
        adc_intr_n <= 1'b1;
        conv_left  <= 0;
      end else if (adc_wr_n && !wr_prev) begin
        conv_left <= conv_len;
      end else if (conv_left == 1) begin
        conv_left  <= 0;
        adc_intr_n <= 1'b0;
        adc_data   <= 8'(seed_v + 8'(37 * conv_k));
        conv_k     <= conv_k + 1;
      end else if (conv_left > 1) begin
        conv_left <= conv_left - 1;
      end
      if (!adc_rd_n && !adc_cs_n) adc_intr_n <= 1'b1;
    end
  end

  // ---------------- monitor (running totals) ----------------
  int   base_k = 0, base_wr = 0;
  int   wr_total = 0, done_total = 0, trig_total = 0;
  int   pw_bad = 0, cs_bad = 0, lat_bad = 0, done_bad = 0;
  int   wr_run = 0, rd_run = 0, cyc = 0, t_int = 0;
  logic p_intr = 1'b1, p_rd = 1'b1, p_wr = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_we) begin
        int idx;
        idx = wr_total - base_wr;
        // R4: address base+k, data of k-th conversion of the run
        chk(mem_addr == 16'(BASE + 16'(idx)), "R4 addr", mem_addr, BASE + idx);
        chk(mem_wdata == 8'(seed_v + 8'(37 * (base_k + idx))), "R4 data",
            mem_wdata, 8'(seed_v + 8'(37 * (base_k + idx))));
        wr_total++;
      end
      if (done) begin
        done_total++;
        if (busy) done_bad++;
      end
      if ((!adc_cs_n) != (!adc_wr_n || !adc_rd_n)) cs_bad++;
      if (!adc_wr_n && !adc_rd_n) cs_bad++;
      if (!adc_wr_n) wr_run++;
      else if (wr_run != 0) begin
        if (wr_run != PW) pw_bad++;
        wr_run = 0;
      end
      if (!adc_rd_n) rd_run++;
      else if (rd_run != 0) begin
        if (rd_run != PW) pw_bad++;
        rd_run = 0;
      end
      if (p_wr && !adc_wr_n) trig_total++;
      if (p_intr && !adc_intr_n) t_int = cyc;
      if (p_rd && !adc_rd_n) begin
        if (adc_intr_n || (cyc - t_int != 3)) lat_bad++;
      end
    end
    p_intr = adc_intr_n;
    p_rd   = adc_rd_n;
    p_wr   = adc_wr_n;
  end

  // ---------------- stimulus ----------------
  task automatic pulse_start(input logic [7:0] n);
    @(negedge clk);
    start_i = 1'b1;
    count_i = n;
    @(negedge clk);
    start_i = 1'b0;
    count_i = 8'h00;
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    while (busy && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic run_capture(input int n, input int conv, input logic [7:0] seed,
                             input bool_busy_poke);
    int w0, d0, pb0, cb0, lb0, db0;
    conv_len = conv;
    seed_v   = seed;
    base_k   = conv_k;
    base_wr  = wr_total;
    w0 = wr_total; d0 = done_total; pb0 = pw_bad; cb0 = cs_bad;
    lb0 = lat_bad; db0 = done_bad;
    pulse_start(8'(n));
    // R2: busy is up after the start request
    chk(busy == 1'b1, "R2 busy", busy, 1);
    if (bool_busy_poke) begin
      repeat (10) @(negedge clk);
      // R7: a second request during the run
      pulse_start(8'd9);
    end
    wait_idle();
    repeat (3) @(negedge clk);
    // R5 / R7: exact number of samples
    chk(wr_total - w0 == n, bool_busy_poke ? "R7 samples" : "R5 samples", wr_total - w0, n);
    // R6
    chk(done_total - d0 == 1, "R6 done count", done_total - d0, 1);
    chk(done_bad == db0, "R6 done with busy", done_bad - db0, 0);
    // R2 / R3 strobe widths
    chk(pw_bad == pb0, "R2 R3 strobe width", pw_bad - pb0, 0);
    // R9
    chk(cs_bad == cb0, "R9 select", cs_bad - cb0, 0);
    // R10
    chk(lat_bad == lb0, "R10 sync latency", lat_bad - lb0, 0);
  endtask

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    count_i = 8'h00;
    repeat (4) @(negedge clk);
    // R1: during reset
    chk({adc_cs_n, adc_wr_n, adc_rd_n} == 3'b111, "R1 strobes in reset",
        {adc_cs_n, adc_wr_n, adc_rd_n}, 7);
    chk({busy, done, mem_we} == 3'b000, "R1 status in reset", {busy, done, mem_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({adc_cs_n, adc_wr_n, adc_rd_n, busy, done, mem_we} == 6'b111000,
        "R1 after release", {adc_cs_n, adc_wr_n, adc_rd_n, busy, done, mem_we}, 56);

    for (int i = 0; i < 6; i++) begin
      run_capture(int'(VEC[i][31:24]), int'(VEC[i][23:8]), VEC[i][7:0], 1'b0);
    end

    // R8: zero count ignored
    begin
      int w0, t0;
      w0 = wr_total; t0 = trig_total;
      pulse_start(8'd0);
      chk(busy == 1'b0, "R8 busy", busy, 0);
      repeat (20) @(negedge clk);
      chk(trig_total == t0, "R8 no trigger", trig_total - t0, 0);
      chk(wr_total == w0, "R8 no write", wr_total - w0, 0);
    end

    // R7: start while busy ignored
    run_capture(3, 30, 8'h44, 1'b1);

    // R5: largest count
    run_capture(255, 1, 8'h07, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule